// File: doc/BRIEF.md
# Segment effective base tracker

This block holds two values for each segment of a processor core. The first is the base that software programmed. The second is the effective base that address generation consumes. There are eight segments. Four of them are legacy data and code segments (extra, code, stack and data), and their effective base is zeroed while the code segment runs in 64-bit mode. The other four segments (the two general-purpose extra segments, the task-state segment and the descriptor-table segment) always use their programmed base.

The block takes base writes, code segment attribute writes that carry the long-mode bit, and the long-mode-active state from the mode logic. Every write is registered. Results appear on the outputs in the cycle after the write. All effective bases are presented in parallel on one flat output. The programmed bases can be read back through a select port.

Top module: `seg_base_track`

## Requirements
- R1: An attribute write that sets the code segment long-mode bit when it was clear makes the effective bases of segments 0..3 (extra, code, stack, data) zero in the next cycle. This applies unless a base write to that same segment is let through in the same cycle.
- R2: An attribute write that clears a long-mode bit that was set reloads the effective bases of segments 0..3 from their programmed bases, in the next cycle.
- R3: A write to segments 4..7 (general extra 1, general extra 2, task state, descriptor table) sets both the programmed base and the effective base of that segment to the written value.
- R4: A write to segments 0..3 updates the effective base only when `lma_i` is low or the code segment long-mode bit is clear. Otherwise the effective base keeps its value.
- R5: Every base write updates the programmed base of the selected segment, whatever the mode. `prog_base_o` shows the programmed base that `prog_sel_i` selects, with no register in the read path.
- R6: An attribute write that leaves the long-mode bit unchanged leaves every effective base unchanged.
- R7: After reset, all bases are zero and the long-mode bit is clear.
- R8: When a base write and an attribute write occur in the same cycle, the attribute write takes effect first. The mode check of the base write uses the new long-mode bit, and a base write that is let through overrides a zeroing or a reload of the same segment.
- R9: `cs_long_o` equals the long-mode bit of the last attribute write. Segment `s` is selected by index `s` on `base_sel_i` and `prog_sel_i`, and its effective base is `eff_base_o[64*s +: 64]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_we_i | input | 1 | Base write strobe |
| base_sel_i | input | 3 | Segment index of the base write |
| base_data_i | input | 64 | Base write value |
| attr_we_i | input | 1 | Code segment attribute write strobe |
| attr_long_i | input | 1 | Long-mode bit of the attribute write |
| lma_i | input | 1 | Long-mode-active state |
| prog_sel_i | input | 3 | Segment index for the programmed-base read |
| prog_base_o | output | 64 | Programmed base of the selected segment |
| cs_long_o | output | 1 | Current code segment long-mode bit |
| eff_base_o | output | 512 | All effective bases, segment s at bits 64*s+63..64*s |

## Verification
The hardest case to reach is a base write to a legacy segment in the same cycle as an attribute write that flips the long-mode bit. The outcome then depends on the ordering rule. Entering 64-bit mode with `lma_i` high must drop the write. Leaving 64-bit mode must let the write override the reload. Directed cycles put both strobes together in each direction. The random phase then drives both strobes at high rates with `lma_i` toggling freely, so that these coincidences recur many times and are compared with a reference model kept in the bench.

// File: rtl/seg_base_pkg.sv
package seg_base_pkg;
  parameter int unsigned BASE_W     = 64;
  parameter int unsigned NUM_SEG    = 8;
  parameter int unsigned NUM_LEGACY = 4;

  // Index order matters: indices below NUM_LEGACY are mode-gated.
  typedef enum logic [2:0] {
    SEG_XS   = 3'd0,
    SEG_CODE = 3'd1,
    SEG_STK  = 3'd2,
    SEG_DAT  = 3'd3,
    SEG_GX1  = 3'd4,
    SEG_GX2  = 3'd5,
    SEG_TSS  = 3'd6,
    SEG_DTAB = 3'd7
  } seg_id_e;
endpackage

// File: rtl/seg_mode_ctl.sv
module seg_mode_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic attr_we_i,
  input  logic attr_long_i,
  input  logic lma_i,
  output logic long_o,
  output logic enter_o,
  output logic leave_o,
  output logic gate_open_o
);
  logic long_q;
  logic long_nxt;

  assign long_nxt    = attr_we_i ? attr_long_i : long_q;
  assign enter_o     = attr_we_i &  attr_long_i & ~long_q;
  assign leave_o     = attr_we_i & ~attr_long_i &  long_q;
  // Legacy base writes see the attribute value of this same cycle
  assign gate_open_o = ~lma_i | ~long_nxt;
  assign long_o      = long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) long_q <= 1'b0;
    else         long_q <= long_nxt;
  end

  AST_LONG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attr_we_i |=> long_o == $past(attr_long_i)); // R9
  AST_LONG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !attr_we_i |=> $stable(long_o)); // R9
endmodule

// File: rtl/seg_base_slot.sv
module seg_base_slot #(
  parameter int unsigned BASE_W = 64,
  parameter bit          LEGACY = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BASE_W-1:0] wdata_i,
  input  logic              enter_i,
  input  logic              leave_i,
  input  logic              gate_open_i,
  output logic [BASE_W-1:0] prog_o,
  output logic [BASE_W-1:0] eff_o
);
  logic [BASE_W-1:0] prog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prog_q <= '0;
    else if (wr_i) prog_q <= wdata_i;
  end
  assign prog_o = prog_q;

  AST_PROG_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> prog_o == $past(wdata_i)); // R5

  if (LEGACY) begin : g_legacy
    logic [BASE_W-1:0] eff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 eff_q <= '0;
      else if (wr_i && gate_open_i) eff_q <= wdata_i;
      else if (enter_i)            eff_q <= '0;
      else if (leave_i)            eff_q <= prog_q;
    end
    assign eff_o = eff_q;

    AST_ENTER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enter_i && !(wr_i && gate_open_i) |=> eff_o == '0); // R1
    AST_LEAVE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      leave_i && !wr_i |=> eff_o == $past(prog_o)); // R2
    AST_GATED_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && !gate_open_i && !enter_i && !leave_i |=> $stable(eff_o)); // R4
    AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && gate_open_i |=> eff_o == $past(wdata_i)); // R8
  end else begin : g_track
    // Effective base is the programmed base; no second register
    assign eff_o = prog_q;
    AST_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> eff_o == $past(wdata_i)); // R3
  end
endmodule

// File: rtl/seg_base_track.sv
module seg_base_track
  import seg_base_pkg::*;
#(
  parameter  int unsigned BASE_W  = seg_base_pkg::BASE_W,
  parameter  int unsigned NUM_SEG = seg_base_pkg::NUM_SEG,
  parameter  int unsigned NUM_LEG = seg_base_pkg::NUM_LEGACY,
  localparam int unsigned SEL_W   = $clog2(NUM_SEG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      base_we_i,
  input  logic [SEL_W-1:0]          base_sel_i,
  input  logic [BASE_W-1:0]         base_data_i,
  input  logic                      attr_we_i,
  input  logic                      attr_long_i,
  input  logic                      lma_i,
  input  logic [SEL_W-1:0]          prog_sel_i,
  output logic [BASE_W-1:0]         prog_base_o,
  output logic                      cs_long_o,
  output logic [NUM_SEG*BASE_W-1:0] eff_base_o
);
  logic enter, leave, gate_open;
  logic [BASE_W-1:0] prog_arr [NUM_SEG];

  seg_mode_ctl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .attr_we_i   (attr_we_i),
    .attr_long_i (attr_long_i),
    .lma_i       (lma_i),
    .long_o      (cs_long_o),
    .enter_o     (enter),
    .leave_o     (leave),
    .gate_open_o (gate_open)
  );

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    logic wr;
    assign wr = base_we_i && (base_sel_i == SEL_W'(i));
    seg_base_slot #(
      .BASE_W (BASE_W),
      .LEGACY (i < NUM_LEG)
    ) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr),
      .wdata_i     (base_data_i),
      .enter_i     (enter),
      .leave_i     (leave),
      .gate_open_i (gate_open),
      .prog_o      (prog_arr[i]),
      .eff_o       (eff_base_o[i*BASE_W +: BASE_W])
    );
  end

  always_comb begin
    prog_base_o = '0;
    for (int i = 0; i < NUM_SEG; i++)
      if (prog_sel_i == SEL_W'(i)) prog_base_o = prog_arr[i];
  end

  AST_NO_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attr_we_i && (attr_long_i == cs_long_o) && !base_we_i |=> $stable(eff_base_o)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !attr_we_i && !base_we_i |=> $stable(eff_base_o)); // R6
endmodule

// File: tb/seg_base_track_tb_top.sv
`timescale 1ns/1ps
module seg_base_track_tb_top;
  localparam int W = 64;
  localparam int N = 8;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, awe = 1'b0, along = 1'b0, lma = 1'b0;
  logic [2:0] sel = '0, psel = '0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] prog_o;
  logic cs_long;
  logic [N*W-1:0] eff_o;

  int checks = 0, errors = 0;
  logic [W-1:0] m_prog [N];
  logic [W-1:0] m_eff  [N];
  logic m_long;

  always #10 clk = ~clk;

  seg_base_track dut_i (
    .clk_i(clk), .rst_ni(rst_n), .base_we_i(we), .base_sel_i(sel),
    .base_data_i(wd), .attr_we_i(awe), .attr_long_i(along), .lma_i(lma),
    .prog_sel_i(psel), .prog_base_o(prog_o), .cs_long_o(cs_long),
    .eff_base_o(eff_o)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string cyc_tag(logic w, logic [2:0] s, logic a, logic al);
    logic tog = a && (al != m_long);
    if (tog && w) return "R8";
    if (tog && al) return "R1";
    if (tog) return "R2";
    if (a) return "R6";
    if (w && s >= L) return "R3";
    return "R4";
  endfunction

  task automatic compare_all(string tag);
    for (int i = 0; i < N; i++) chk(tag, eff_o[i*W +: W], m_eff[i]);
    chk("R9", {63'd0, cs_long}, {63'd0, m_long});
    for (int i = 0; i < N; i++) begin
      psel = 3'(i);
      #1;
      chk("R5", prog_o, m_prog[i]);
    end
  endtask

  // Drive one cycle at negedge, update the model, compare at the next negedge
  task automatic cyc(logic w, logic [2:0] s, logic [W-1:0] d,
                     logic a, logic al, logic lm, string tag);
    logic nl, ent, lea;
    logic [W-1:0] old_prog [N];
    we = w; sel = s; wd = d; awe = a; along = al; lma = lm;
    if (tag == "") tag = cyc_tag(w, s, a, al);
    nl  = a ? al : m_long;
    ent = a && al && !m_long;
    lea = a && !al && m_long;
    for (int i = 0; i < N; i++) old_prog[i] = m_prog[i];
    for (int i = 0; i < N; i++) begin
      logic hit = w && (s == 3'(i));
      if (hit) m_prog[i] = d;
      if (i >= L) begin
        if (hit) m_eff[i] = d;
      end else if (hit && (!lm || !nl)) m_eff[i] = d;
      else if (ent) m_eff[i] = '0;
      else if (lea) m_eff[i] = old_prog[i];
    end
    m_long = nl;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; awe = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < N; i++) begin m_prog[i] = '0; m_eff[i] = '0; end
    m_long = 1'b0;
    repeat (3) @(negedge clk);
    compare_all("R7");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R7");

    cyc(1, 3'd0, 64'hAAAA_0000_1111_2222, 0, 0, 0, "R4");
    cyc(1, 3'd4, 64'hBBBB_3333_4444_5555, 0, 0, 0, "R3");
    cyc(1, 3'd3, 64'hDDDD_0000_0000_0003, 0, 0, 0, "R4");
    cyc(0, 3'd0, '0, 1, 1, 1, "R1");
    cyc(1, 3'd3, 64'hCCCC_1234_5678_9ABC, 0, 0, 1, "R4");
    cyc(1, 3'd6, 64'hEEEE_0000_0000_0006, 0, 0, 1, "R3");
    cyc(0, 3'd0, '0, 1, 1, 1, "R6");
    cyc(1, 3'd2, 64'h1111_2222_3333_4444, 0, 0, 0, "R4");
    cyc(0, 3'd0, '0, 1, 0, 1, "R2");
    cyc(0, 3'd0, '0, 1, 0, 0, "R6");
    cyc(1, 3'd1, 64'hD00D_0000_0000_0001, 1, 1, 1, "R8");
    cyc(1, 3'd2, 64'hE00E_0000_0000_0002, 1, 0, 1, "R8");
    cyc(1, 3'd0, 64'hF00F_0000_0000_0003, 1, 1, 0, "R8");

    for (int k = 0; k < 3000; k++) begin
      logic w  = ($urandom_range(0, 3) != 0);
      logic a  = ($urandom_range(0, 2) == 0);
      logic [W-1:0] d = {$urandom, $urandom};
      cyc(w, 3'($urandom_range(0, N-1)), d, a, 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule